// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the software-facing register window of one DMA channel. A write to its command word does not store data: every bit of the word is a one-shot command that sets or clears one flag of the channel, triggers a transfer or resets the channel. A status word reports whether the channel runs and which events it has seen. Two plain storage words hold the configuration and the address of the first descriptor that the descriptor engine fetches.

The block drives single-cycle start, trigger, stop and soft-reset pulses to the descriptor engine. It takes end, error and terminal-count events and the peripheral request line back from the engine or its stub. It merges the error flag and the unmasked end flag into one level interrupt that stays high until software acknowledges the cause.

Software starts a channel in four writes: the descriptor address, the configuration, a soft reset on its own, and then set-enable together with the software trigger. A single write of every clear bit plus soft reset stops the channel and leaves it clean.

Top module: `dmac_chan_regs`

## Requirements
- R1: Byte offsets in the 64-byte window are: status 0x24, command 0x28 (reads as zero), configuration 0x2C, descriptor address 0x38. Other offsets read as zero, and writes to them change nothing.
- R2: Command bit 0 (set-enable), written while the channel is disabled and with neither bit 1 nor bit 3, sets status bit 0 and gives a one-cycle start_o pulse in the cycle after the write. Command bit 2 (trigger) gives a one-cycle trig_o pulse in that cycle if the channel is enabled after the write.
- R3: Command bit 1 (clear-enable), written while the channel runs, clears status bit 0 and gives a one-cycle stop_o pulse.
- R4: When a set bit and its clear bit come in the same write, the clear wins: enable (bits 0/1), suspend (bits 8/9, status bit 5), interrupt mask (bits 16/17, status bit 16).
- R5: Command bit 3 (soft reset) clears status bits 0 to 5, gives a one-cycle swrst_o pulse, gives stop_o if the channel was running, beats a set-enable in the same write and drops engine events of that cycle.
- R6: Soft reset leaves the configuration word, the descriptor address and the interrupt mask unchanged.
- R7: An end event while enabled sets status bit 3 and clears status bit 0. Command bit 5 clears status bit 3. An end event in the same cycle as that clear wins.
- R8: An error event while enabled sets status bit 4 and clears status bit 0. Only soft reset clears status bit 4.
- R9: A terminal-count event while enabled sets status bit 2, cleared by command bit 6. The request input while enabled sets status bit 1, cleared by command bit 4.
- R10: End, error and terminal-count events and the request input have no effect while the channel is disabled.
- R11: irq_o is high while status bit 4 is set, or while status bit 3 is set and the mask (status bit 16) is clear. It holds until the cause is cleared or masked.
- R12: The stop word 0x0002027A (bits 1, 3, 4, 5, 6, 9, 17) leaves the channel disabled with every status bit clear and irq_o low.
- R13: The start sequence of descriptor address, configuration, soft reset alone, then bits 0 and 2 together, leaves both words on cfg_o and nxla_o and gives start_o and trig_o together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | ADDR_W | Byte offset inside the channel window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| dreq_i | input | 1 | Peripheral request level |
| ev_end_i | input | 1 | End event from the descriptor engine |
| ev_err_i | input | 1 | Error event from the descriptor engine |
| ev_tc_i | input | 1 | Terminal-count event from the descriptor engine |
| start_o | output | 1 | Start pulse to the engine |
| trig_o | output | 1 | Software trigger pulse |
| stop_o | output | 1 | Stop pulse |
| swrst_o | output | 1 | Soft reset pulse |
| en_o | output | 1 | Channel enabled |
| cfg_o | output | DATA_W | Configuration word |
| nxla_o | output | DATA_W | First descriptor address |
| irq_o | output | 1 | Channel interrupt |

## Verification
Every flag, word and pulse is registered on the clock edge that ends the write or event cycle. So status, en_o, irq_o and the words change one cycle after the stimulus, and the four pulses are high for exactly that one cycle. The bench drives each stimulus for one cycle starting at a falling edge and samples at the next falling edge. It then samples again one cycle later to confirm that each pulse has dropped. The read data is a combinational function of the address, so it is sampled 1 ns after the address is applied with no edge in between.

// File: rtl/dmac_chan_pkg.sv
package dmac_chan_pkg;

  localparam int unsigned OFF_STAT = 'h24;
  localparam int unsigned OFF_CTRL = 'h28;
  localparam int unsigned OFF_CFG  = 'h2C;
  localparam int unsigned OFF_NXLA = 'h38;

  localparam int CB_SETEN  = 0;
  localparam int CB_CLREN  = 1;
  localparam int CB_STG    = 2;
  localparam int CB_SWRST  = 3;
  localparam int CB_CLRRQ  = 4;
  localparam int CB_CLREND = 5;
  localparam int CB_CLRTC  = 6;
  localparam int CB_SETSUS = 8;
  localparam int CB_CLRSUS = 9;
  localparam int CB_SETMSK = 16;
  localparam int CB_CLRMSK = 17;

  localparam int SB_EN  = 0;
  localparam int SB_RQ  = 1;
  localparam int SB_TC  = 2;
  localparam int SB_END = 3;
  localparam int SB_ER  = 4;
  localparam int SB_SUS = 5;
  localparam int SB_MSK = 16;

  localparam int NWORD   = 2;
  localparam int WI_CFG  = 0;
  localparam int WI_NXLA = 1;

  typedef struct packed {
    logic seten;
    logic clren;
    logic stg;
    logic swrst;
    logic clrrq;
    logic clrend;
    logic clrtc;
    logic setsus;
    logic clrsus;
    logic setmsk;
    logic clrmsk;
  } cmd_t;

  typedef struct packed {
    logic en;
    logic rq;
    logic tc;
    logic fin;
    logic er;
    logic sus;
    logic msk;
  } flags_t;

  function automatic int unsigned word_off(input int idx);
    return (idx == WI_CFG) ? OFF_CFG : OFF_NXLA;
  endfunction

endpackage

// File: rtl/dmac_chan_decode.sv
module dmac_chan_decode
  import dmac_chan_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cmd_t              cmd_o,
  output logic [NWORD-1:0]  word_we_o,
  output logic [DATA_W-1:0] word_d_o
);

  logic hit_ctrl;
  assign hit_ctrl = wr_en_i && (addr_i == ADDR_W'(OFF_CTRL));

  assign cmd_o.seten  = hit_ctrl & wdata_i[CB_SETEN];
  assign cmd_o.clren  = hit_ctrl & wdata_i[CB_CLREN];
  assign cmd_o.stg    = hit_ctrl & wdata_i[CB_STG];
  assign cmd_o.swrst  = hit_ctrl & wdata_i[CB_SWRST];
  assign cmd_o.clrrq  = hit_ctrl & wdata_i[CB_CLRRQ];
  assign cmd_o.clrend = hit_ctrl & wdata_i[CB_CLREND];
  assign cmd_o.clrtc  = hit_ctrl & wdata_i[CB_CLRTC];
  assign cmd_o.setsus = hit_ctrl & wdata_i[CB_SETSUS];
  assign cmd_o.clrsus = hit_ctrl & wdata_i[CB_CLRSUS];
  assign cmd_o.setmsk = hit_ctrl & wdata_i[CB_SETMSK];
  assign cmd_o.clrmsk = hit_ctrl & wdata_i[CB_CLRMSK];

  for (genvar gi = 0; gi < NWORD; gi++) begin : g_we
    assign word_we_o[gi] = wr_en_i && (addr_i == ADDR_W'(word_off(gi)));
  end

  assign word_d_o = wdata_i;

endmodule

// File: rtl/dmac_chan_words.sv
module dmac_chan_words
  import dmac_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NWORD-1:0]             we_i,
  input  logic [DATA_W-1:0]            d_i,
  input  logic                         swrst_i,
  output logic [NWORD-1:0][DATA_W-1:0] q_o
);

  for (genvar gi = 0; gi < NWORD; gi++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[gi] <= '0;
      else if (we_i[gi]) q_o[gi] <= d_i;
    end

    // R6: soft reset never disturbs a stored word
    a_r6_word_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swrst_i && !we_i[gi]) |=> $stable(q_o[gi]));
  end

endmodule

// File: rtl/dmac_chan_flags.sv
module dmac_chan_flags
  import dmac_chan_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  cmd_t   cmd_i,
  input  logic   dreq_i,
  input  logic   ev_end_i,
  input  logic   ev_err_i,
  input  logic   ev_tc_i,
  output flags_t flags_o,
  output logic   start_o,
  output logic   trig_o,
  output logic   stop_o,
  output logic   swrst_o,
  output logic   irq_o
);

  flags_t q, d;
  logic   ev_end, ev_err, ev_tc, ev_rq;
  logic   start_q, trig_q, stop_q, swrst_q;

  // engine events count only while running and not during a soft reset
  assign ev_end = ev_end_i & q.en & ~cmd_i.swrst;
  assign ev_err = ev_err_i & q.en & ~cmd_i.swrst;
  assign ev_tc  = ev_tc_i  & q.en & ~cmd_i.swrst;
  assign ev_rq  = dreq_i   & q.en & ~cmd_i.swrst;

  always_comb begin
    d = q;
    if (cmd_i.swrst) begin
      d.en  = 1'b0;
      d.rq  = 1'b0;
      d.tc  = 1'b0;
      d.fin = 1'b0;
      d.er  = 1'b0;
      d.sus = 1'b0;
    end else begin
      if (cmd_i.seten)     d.en = 1'b1;
      if (ev_end | ev_err) d.en = 1'b0;
      if (cmd_i.clren)     d.en = 1'b0;
      if (cmd_i.clrrq)     d.rq = 1'b0;
      if (ev_rq)           d.rq = 1'b1;
      if (cmd_i.clrtc)     d.tc = 1'b0;
      if (ev_tc)           d.tc = 1'b1;
      if (cmd_i.clrend)    d.fin = 1'b0;
      if (ev_end)          d.fin = 1'b1;
      if (ev_err)          d.er = 1'b1;
      if (cmd_i.setsus)    d.sus = 1'b1;
      if (cmd_i.clrsus)    d.sus = 1'b0;
    end
    if (cmd_i.setmsk) d.msk = 1'b1;
    if (cmd_i.clrmsk) d.msk = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= '0;
      start_q <= 1'b0;
      trig_q  <= 1'b0;
      stop_q  <= 1'b0;
      swrst_q <= 1'b0;
    end else begin
      q       <= d;
      start_q <= cmd_i.seten & ~q.en & ~cmd_i.clren & ~cmd_i.swrst;
      trig_q  <= cmd_i.stg & d.en;
      stop_q  <= q.en & (cmd_i.clren | cmd_i.swrst);
      swrst_q <= cmd_i.swrst;
    end
  end

  assign flags_o = q;
  assign start_o = start_q;
  assign trig_o  = trig_q;
  assign stop_o  = stop_q;
  assign swrst_o = swrst_q;
  assign irq_o   = q.er | (q.fin & ~q.msk);

  a_r2_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);

  a_r3_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_q, stop_q}));

  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.seten && cmd_i.clren) |=> !q.en);

  a_r5_swrst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.swrst |=> (!q.en && !q.rq && !q.tc && !q.fin && !q.er && !q.sus));

  a_r6_msk_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.swrst && !cmd_i.setmsk && !cmd_i.clrmsk) |=> $stable(q.msk));

  a_r7_end_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.clrend && !ev_end_i) |=> !q.fin);

  a_r10_idle_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q.en |=> !$rose(q.er));

  a_r10_idle_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q.en |=> !$rose(q.tc));

  a_r11_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !cmd_i.swrst && !cmd_i.clrend && !cmd_i.setmsk) |=> irq_o);

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_chan_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dreq_i,
  input  logic              ev_end_i,
  input  logic              ev_err_i,
  input  logic              ev_tc_i,
  output logic              start_o,
  output logic              trig_o,
  output logic              stop_o,
  output logic              swrst_o,
  output logic              en_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] nxla_o,
  output logic              irq_o
);

  cmd_t                         cmd;
  logic [NWORD-1:0]             word_we;
  logic [DATA_W-1:0]            word_d;
  logic [NWORD-1:0][DATA_W-1:0] words;
  flags_t                       flags;
  logic [DATA_W-1:0]            stat_word;

  dmac_chan_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd),
    .word_we_o (word_we),
    .word_d_o  (word_d)
  );

  dmac_chan_words #(.DATA_W(DATA_W)) u_words (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (word_we),
    .d_i     (word_d),
    .swrst_i (cmd.swrst),
    .q_o     (words)
  );

  dmac_chan_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .dreq_i   (dreq_i),
    .ev_end_i (ev_end_i),
    .ev_err_i (ev_err_i),
    .ev_tc_i  (ev_tc_i),
    .flags_o  (flags),
    .start_o  (start_o),
    .trig_o   (trig_o),
    .stop_o   (stop_o),
    .swrst_o  (swrst_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    stat_word         = '0;
    stat_word[SB_EN]  = flags.en;
    stat_word[SB_RQ]  = flags.rq;
    stat_word[SB_TC]  = flags.tc;
    stat_word[SB_END] = flags.fin;
    stat_word[SB_ER]  = flags.er;
    stat_word[SB_SUS] = flags.sus;
    stat_word[SB_MSK] = flags.msk;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_STAT))      rdata_o = stat_word;
    else if (addr_i == ADDR_W'(OFF_CFG))  rdata_o = words[WI_CFG];
    else if (addr_i == ADDR_W'(OFF_NXLA)) rdata_o = words[WI_NXLA];
  end

  assign en_o   = flags.en;
  assign cfg_o  = words[WI_CFG];
  assign nxla_o = words[WI_NXLA];

  a_r2_start_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> en_o);

  a_r3_stop_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !en_o);

  a_r8_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_err_i && en_o && !cmd.swrst) |=> (!en_o && irq_o));

endmodule

// File: tb/sim_dmac_chan_regs.sv
`timescale 1ns/1ps
module sim_dmac_chan_regs;

  localparam logic [5:0] A_STAT = 6'h24;
  localparam logic [5:0] A_CTRL = 6'h28;
  localparam logic [5:0] A_CFG  = 6'h2C;
  localparam logic [5:0] A_NXLA = 6'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dreq = 1'b0, ev_end = 1'b0, ev_err = 1'b0, ev_tc = 1'b0;
  logic        start, trig, stop, swrst, en, irq;
  logic [31:0] cfg, nxla;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dmac_chan_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .dreq_i(dreq), .ev_end_i(ev_end), .ev_err_i(ev_err),
    .ev_tc_i(ev_tc), .start_o(start), .trig_o(trig), .stop_o(stop),
    .swrst_o(swrst), .en_o(en), .cfg_o(cfg), .nxla_o(nxla), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus from a falling edge; returns at the next falling edge
  task automatic drive(input logic w, input logic [5:0] a, input logic [31:0] d,
                       input logic e_end, input logic e_err, input logic e_tc,
                       input logic rq);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d;
    ev_end = e_end; ev_err = e_err; ev_tc = e_tc; dreq = rq;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    ev_end = 1'b0; ev_err = 1'b0; ev_tc = 1'b0; dreq = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic chk_stat(input string req, input logic [31:0] exp);
    logic [31:0] v;
    rd(A_STAT, v);
    chk(req, "status", v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk_stat("R1", 32'h0);
    rd(A_CTRL, v); chk("R1", "ctrl read", v, 32'h0);
    rd(A_CFG, v);  chk("R1", "cfg read", v, 32'h0);
    rd(A_NXLA, v); chk("R1", "nxla read", v, 32'h0);
    chk("R11", "irq at reset", {31'b0, irq}, 32'h0);
    chk("R2", "pulses at reset", {28'b0, start, trig, stop, swrst}, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_CFG, 32'hA5A5_0001);
    wr(A_NXLA, 32'h1000_0040);
    rd(A_CFG, v);  chk("R1", "cfg readback", v, 32'hA5A5_0001);
    rd(A_NXLA, v); chk("R1", "nxla readback", v, 32'h1000_0040);
    wr(A_CTRL, 32'h0000_0100);
    rd(A_CTRL, v); chk("R1", "ctrl reads zero", v, 32'h0);
    wr(A_CTRL, 32'h0000_0200);
    wr(6'h30, 32'hFFFF_FFFF);
    rd(6'h30, v);  chk("R1", "unmapped read", v, 32'h0);
    chk_stat("R1", 32'h0);
    chk("R1", "cfg after unmapped write", cfg, 32'hA5A5_0001);
    chk("R1", "nxla after unmapped write", nxla, 32'h1000_0040);
  endtask

  task automatic t_start_seq;
    wr(A_NXLA, 32'h0000_2000);
    wr(A_CFG, 32'h8040_0008);
    wr(A_CTRL, 32'h8);
    chk("R13", "swrst pulse", {31'b0, swrst}, 32'h1);
    chk("R5", "no stop when idle", {31'b0, stop}, 32'h0);
    wr(A_CTRL, 32'h5);
    chk("R2", "start pulse", {31'b0, start}, 32'h1);
    chk("R13", "trig with start", {31'b0, trig}, 32'h1);
    chk("R2", "en after start", {31'b0, en}, 32'h1);
    chk("R13", "cfg held", cfg, 32'h8040_0008);
    chk("R13", "nxla held", nxla, 32'h0000_2000);
    @(negedge clk);
    chk("R2", "pulses drop", {30'b0, start, trig}, 32'h0);
    chk_stat("R2", 32'h1);
  endtask

  task automatic t_trig_stop;
    wr(A_CTRL, 32'h4);
    chk("R2", "trig while enabled", {30'b0, trig, start}, 32'h2);
    wr(A_CTRL, 32'h2);
    chk("R3", "stop pulse", {31'b0, stop}, 32'h1);
    chk("R3", "en cleared", {31'b0, en}, 32'h0);
    @(negedge clk);
    chk("R3", "stop drops", {31'b0, stop}, 32'h0);
    chk_stat("R3", 32'h0);
  endtask

  task automatic t_clear_wins;
    wr(A_CTRL, 32'h3);
    chk("R4", "enable set+clear", {30'b0, en, start}, 32'h0);
    wr(A_CTRL, 32'h300);
    chk_stat("R4", 32'h0);
    wr(A_CTRL, 32'h30000);
    chk_stat("R4", 32'h0);
    wr(A_CTRL, 32'h100);
    chk_stat("R4", 32'h20);
    wr(A_CTRL, 32'h200);
    chk_stat("R4", 32'h0);
  endtask

  task automatic t_end;
    wr(A_CTRL, 32'h1);
    drive(1'b0, A_STAT, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_stat("R7", 32'h8);
    chk("R11", "irq on end", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h20);
    chk_stat("R7", 32'h0);
    chk("R7", "irq after ack", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h1);
    drive(1'b1, A_CTRL, 32'h20, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_stat("R7", 32'h8);
    wr(A_CTRL, 32'h20);
    chk_stat("R7", 32'h0);
  endtask

  task automatic t_mask;
    wr(A_CTRL, 32'h10000);
    chk_stat("R11", 32'h10000);
    wr(A_CTRL, 32'h1);
    drive(1'b0, A_STAT, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_stat("R11", 32'h10008);
    chk("R11", "masked end", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h20000);
    chk("R11", "unmasked end", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h20);
    chk("R11", "irq after ack", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_err;
    wr(A_CTRL, 32'h1);
    drive(1'b0, A_STAT, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_stat("R8", 32'h10);
    chk("R8", "irq and en on error", {30'b0, irq, en}, 32'h2);
    wr(A_CTRL, 32'h20);
    chk_stat("R8", 32'h10);
    wr(A_CTRL, 32'h8);
    chk_stat("R8", 32'h0);
    chk("R8", "irq after swrst", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tc_rq;
    wr(A_CTRL, 32'h1);
    drive(1'b0, A_STAT, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk_stat("R9", 32'h7);
    wr(A_CTRL, 32'h40);
    chk_stat("R9", 32'h3);
    wr(A_CTRL, 32'h10);
    chk_stat("R9", 32'h1);
    wr(A_CTRL, 32'h2);
  endtask

  task automatic t_idle;
    drive(1'b0, A_STAT, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk_stat("R10", 32'h0);
    chk("R10", "irq when idle", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_swrst;
    wr(A_CFG, 32'h0000_1234);
    wr(A_NXLA, 32'h0000_0080);
    wr(A_CTRL, 32'h10000);
    wr(A_CTRL, 32'h1);
    drive(1'b0, A_STAT, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk_stat("R5", 32'h10005);
    wr(A_CTRL, 32'h9);
    chk("R5", "stop/swrst/start", {29'b0, stop, swrst, start}, 32'h6);
    chk_stat("R6", 32'h10000);
    chk("R6", "cfg kept", cfg, 32'h0000_1234);
    chk("R6", "nxla kept", nxla, 32'h0000_0080);
    wr(A_CTRL, 32'h1);
    drive(1'b1, A_CTRL, 32'h8, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_stat("R5", 32'h10000);
    wr(A_CTRL, 32'h20000);
  endtask

  task automatic t_stop_word;
    wr(A_CTRL, 32'h10000);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h100);
    drive(1'b0, A_STAT, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk_stat("R12", 32'h10027);
    wr(A_CTRL, 32'h0002_027A);
    chk("R12", "stop and swrst pulses", {30'b0, stop, swrst}, 32'h3);
    chk_stat("R12", 32'h0);
    chk("R12", "en and irq", {30'b0, en, irq}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_start_seq();
    t_trig_stop();
    t_clear_wins();
    t_end();
    t_mask();
    t_err();
    t_tc_rq();
    t_idle();
    t_swrst();
    t_stop_word();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule